// File: doc/BRIEF.md
# Maskable Interrupt Aggregator

The block gathers five event sources from a sensor core into one latched status word and one combined interrupt line. Two sources describe the sample buffer: its fill level has reached the programmed threshold, or the buffer is full. Two are event inputs: a new sample is ready, and the pressure reading has left its allowed window. The fifth records that the core has come out of power-on reset. The first four each have an enable bit. The power-on source has no enable bit and cannot be masked.

A bit in the status word stays set until the host reads the word. The read strobe clears the word at the next clock edge, and any event that arrives in the same cycle as the read still lands in the new word. The two buffer sources follow their level inputs, and a set bit stays latched after its condition drops. When the host writes a new threshold, the threshold bit is recomputed from the current comparison result. A buffer flush clears both buffer bits. The interrupt line is the OR of all status bits. The host decides what to service by reading the status word.

Top module: `irq_aggregator`

## Requirements
- R1: After reset is released, status is 5'b10000 (bit 4 = power-on) and irq is 1.
- R2: The first read strobe clears status bit 4. The power-on bit never sets again until the next reset.
- R3: Status bit 0 (data ready) sets in the cycle after a rising edge of drdy_evt while src_en[0] is 1. A drdy_evt held high does not set the bit again after a read.
- R4: Status bit 3 (out-of-range) sets in the cycle after a rising edge of oor_evt while src_en[3] is 1. It is edge-triggered like bit 0.
- R5: Status bit 1 (full) follows fifo_full and bit 2 (threshold) follows fifo_thr_hit while src_en[1] and src_en[2] are set. Each bit stays set after its condition drops, until a read.
- R6: A source whose src_en bit (bits 0..3 map to status bits 0..3) is 0 shows 0 in status and does not raise irq. Clearing the enable bit also clears a bit that was already latched.
- R7: irq is 1 exactly when any status bit is 1.
- R8: A cycle with thr_wr high loads status bit 2 with src_en[2] AND fifo_thr_hit, whatever its prior value. This can set the bit or clear it.
- R9: A cycle with fifo_flush high clears status bits 1 and 2. The flush takes priority over the level inputs, the threshold write and the previous value.
- R10: An event that sets a status bit in the same cycle as a read strobe is set in status after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_en | input | 4 | Enables: 0 data ready, 1 full, 2 threshold, 3 out-of-range |
| drdy_evt | input | 1 | Data-ready event, edge-detected |
| oor_evt | input | 1 | Pressure out-of-range event, edge-detected |
| fifo_full | input | 1 | Buffer full level |
| fifo_thr_hit | input | 1 | Buffer level at or above threshold |
| thr_wr | input | 1 | Threshold register write strobe |
| fifo_flush | input | 1 | Buffer flush strobe |
| rd_stb | input | 1 | Host read of the status word |
| status | output | 5 | Latched status: 4 power-on, 3 out-of-range, 2 threshold, 1 full, 0 data ready |
| irq | output | 1 | Combined interrupt |

## Verification
All internal state is the five status bits and two edge-detect flops, so a wrong state appears on the status port one cycle after the edge that caused it. A stale edge-detect flop shows up as a missing set or an extra set of bit 0 or bit 3. A wrong priority among read, flush and threshold write shows up as a wrong bit 1 or bit 2 in the cycle after the collision. The bench compares the full status word and irq against a reference model on every cycle, so any divergence is caught within one clock.

// File: rtl/irq_aggregator.sv
module irq_aggregator (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] src_en,
  input  logic       drdy_evt,
  input  logic       oor_evt,
  input  logic       fifo_full,
  input  logic       fifo_thr_hit,
  input  logic       thr_wr,
  input  logic       fifo_flush,
  input  logic       rd_stb,
  output logic [4:0] status,
  output logic       irq
);

  logic       drdy_q, oor_q;
  logic [4:0] st, hit, nxt;

  assign hit[0] = src_en[0] & drdy_evt & ~drdy_q;
  assign hit[1] = src_en[1] & fifo_full;
  assign hit[2] = src_en[2] & fifo_thr_hit;
  assign hit[3] = src_en[3] & oor_evt & ~oor_q;
  assign hit[4] = 1'b0;

  always_comb begin
    nxt = (rd_stb ? 5'b0 : st) | hit;
    if (thr_wr)     nxt[2]   = hit[2];
    if (fifo_flush) nxt[2:1] = 2'b00;
    nxt[3:0] = nxt[3:0] & src_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= 5'b10000;
      drdy_q <= 1'b0;
      oor_q  <= 1'b0;
    end else begin
      st     <= nxt;
      drdy_q <= drdy_evt;
      oor_q  <= oor_evt;
    end
  end

  assign status = st;
  assign irq    = |st;

  assert_por_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !status[4]);
  assert_por_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && status[4]) |=> status[4]);
  assert_drdy_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(drdy_evt) && src_en[0]) |=> (status[0] && irq));
  assert_mask_drdy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !src_en[0] |=> !status[0]);
  assert_mask_oor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !src_en[3] |=> !status[3]);
  assert_thr_reeval_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !fifo_flush) |=> (status[2] == $past(src_en[2] && fifo_thr_hit)));
  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |=> (!status[1] && !status[2]));
  assert_rd_keeps_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && fifo_full && src_en[1] && !fifo_flush) |=> status[1]);

endmodule

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] src_en = 4'h0;
  logic       drdy_evt = 1'b0, oor_evt = 1'b0, fifo_full = 1'b0, fifo_thr_hit = 1'b0;
  logic       thr_wr = 1'b0, fifo_flush = 1'b0, rd_stb = 1'b0;
  logic [4:0] status;
  logic       irq;

  int unsigned vectors = 0, errors = 0;
  logic [4:0] exp_st = 5'b10000;
  logic       prev_drdy = 1'b0, prev_oor = 1'b0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  irq_aggregator u_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .drdy_evt(drdy_evt), .oor_evt(oor_evt),
    .fifo_full(fifo_full), .fifo_thr_hit(fifo_thr_hit), .thr_wr(thr_wr),
    .fifo_flush(fifo_flush), .rd_stb(rd_stb), .status(status), .irq(irq));

  function automatic logic [4:0] model_next(logic [4:0] cur);
    logic [4:0] r;
    r = rd_stb ? 5'b0 : cur;
    if (src_en[0] && drdy_evt && !prev_drdy) r[0] = 1'b1;
    if (src_en[3] && oor_evt && !prev_oor)   r[3] = 1'b1;
    if (src_en[1] && fifo_full)              r[1] = 1'b1;
    if (thr_wr)                              r[2] = src_en[2] && fifo_thr_hit;
    else if (src_en[2] && fifo_thr_hit)      r[2] = 1'b1;
    if (fifo_flush) begin r[1] = 1'b0; r[2] = 1'b0; end
    for (int i = 0; i < 4; i++) if (!src_en[i]) r[i] = 1'b0;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R3 data-ready bit",   {4'b0, status[0]}, {4'b0, exp_st[0]});
    chk("R5 full bit",         {4'b0, status[1]}, {4'b0, exp_st[1]});
    chk("R5 threshold bit",    {4'b0, status[2]}, {4'b0, exp_st[2]});
    chk("R4 out-of-range bit", {4'b0, status[3]}, {4'b0, exp_st[3]});
    chk("R2 power-on bit",     {4'b0, status[4]}, {4'b0, exp_st[4]});
    chk("R7 irq",              {4'b0, irq},       {4'b0, |exp_st});
  endtask

  task automatic cyc();
    @(posedge clk);
    exp_st = model_next(exp_st);
    prev_drdy = drdy_evt;
    prev_oor  = oor_evt;
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    drdy_evt = 0; oor_evt = 0; fifo_full = 0; fifo_thr_hit = 0;
    thr_wr = 0; fifo_flush = 0; rd_stb = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset status", status, 5'b10000);
    chk("R1 reset irq", {4'b0, irq}, 5'b00001);

    rd_stb = 1; cyc(); rd_stb = 0;
    chk("R2 power-on cleared", status, 5'b00000);
    cyc(); cyc();
    chk("R2 power-on stays clear", status, 5'b00000);

    src_en = 4'hF;
    drdy_evt = 1; cyc();
    chk("R3 data-ready set", status, 5'b00001);
    rd_stb = 1; cyc(); rd_stb = 0; cyc();
    chk("R3 held level no re-set", status, 5'b00000);
    drdy_evt = 0; cyc();

    oor_evt = 1; cyc(); oor_evt = 0; cyc();
    chk("R4 out-of-range latched", status, 5'b01000);
    rd_stb = 1; cyc(); rd_stb = 0;

    fifo_full = 1; cyc(); fifo_full = 0; cyc(); cyc();
    chk("R5 full stays latched", status, 5'b00010);
    rd_stb = 1; cyc(); rd_stb = 0; cyc();
    chk("R5 full cleared by read", status, 5'b00000);

    src_en = 4'hE; drdy_evt = 1; cyc(); drdy_evt = 0; cyc();
    chk("R6 masked data-ready", {status, irq}, 6'b000000);
    src_en = 4'hF; fifo_full = 1; cyc(); fifo_full = 0;
    src_en = 4'hD; cyc();
    chk("R6 disable clears latched", status, 5'b00000);
    src_en = 4'hF;

    fifo_thr_hit = 1; cyc(); fifo_thr_hit = 0; thr_wr = 1; cyc(); thr_wr = 0;
    chk("R8 threshold write clears", status, 5'b00000);
    src_en = 4'hB; fifo_thr_hit = 1; cyc(); src_en = 4'hF; thr_wr = 1; cyc(); thr_wr = 0;
    fifo_thr_hit = 0;
    chk("R8 threshold write sets", status, 5'b00100);
    rd_stb = 1; cyc(); rd_stb = 0;

    fifo_full = 1; fifo_thr_hit = 1; cyc();
    fifo_flush = 1; thr_wr = 1; cyc(); idle();
    chk("R9 flush clears buffer bits", status, 5'b00000);

    rd_stb = 1; drdy_evt = 1; cyc(); idle();
    chk("R10 same-cycle event kept", status, 5'b00001);
    rd_stb = 1; cyc(); rd_stb = 0;

    for (int n = 0; n < 4000; n++) begin
      if (($urandom % 8) == 0) src_en = 4'($urandom);
      drdy_evt     = ($urandom % 3) == 0;
      oor_evt      = ($urandom % 4) == 0;
      fifo_full    = ($urandom % 5) == 0;
      fifo_thr_hit = ($urandom % 3) == 0;
      thr_wr       = ($urandom % 9) == 0;
      fifo_flush   = ($urandom % 11) == 0;
      rd_stb       = ($urandom % 4) == 0;
      cyc();
    end
    idle();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule